// File: doc/BRIEF.md
# In-Order Issue Stall Interlock

This block sits in the decode stage of a single-issue, in-order pipeline that has an integer unit and a floating-point unit. It watches the instruction currently held in decode: its class, its destination register and its two source register fields. It decides whether that instruction may issue this cycle. For every architectural register it keeps a small countdown. The countdown starts when a producer of that register issues and runs down by one each cycle. The wait a consumer needs is not a single forwarding distance. It depends on which class produced the value and which class is reading it.

When any source the decoded instruction actually reads still needs time, the block raises `stall` and the pipeline must hold the instruction in decode. When no wait remains, `issue` is raised for one cycle. In that same cycle the countdown of the instruction's destination register is armed. A branch is treated like any other sequential instruction, so the instruction after a branch goes through the same checks.

Top module: `issue_interlock`

## Requirements
- R1: A synchronous reset clears every countdown, so the first valid instruction after reset issues with zero stall cycles. While reset is held and no instruction is valid, `stall` and `issue` are both low.
- R2: An FP ALU operation (class code 3) that reads, through either source field, the destination of an FP ALU operation issued in the previous cycle stalls for exactly 3 cycles.
- R3: A store double (class code 5, base register in the first source field from the integer file, data register in the second source field from the FP file) whose data comes from an FP ALU operation issued in the previous cycle stalls for exactly 2 cycles.
- R4: An FP ALU operation reading the destination of a load double (class code 4, base register in the first source field, FP destination) issued in the previous cycle stalls for exactly 1 cycle.
- R5: A store double whose data comes from a load double issued in the previous cycle stalls for 0 cycles.
- R6: An integer operation (class code 1, both sources and the destination in the integer file) reads an integer result from the previous cycle with 0 stall cycles. The same holds for the base register of a load or store.
- R7: A conditional branch (class code 2, tests the integer register in the first source field) that reads the destination of the integer operation issued in the previous cycle stalls for exactly 1 cycle.
- R8: Integer register 0 never causes a stall. Writing it arms no countdown.
- R9: The wait still owed for a source is the pair latency minus the cycles elapsed since the producer issued. Cycles that pass during unrelated issues and during stalls both count.
- R10: A stalled instruction arms no countdown until the cycle it issues. An FP ALU operation that reads and rewrites the register of the FP ALU operation just before it therefore stalls exactly 3 cycles, not longer.
- R11: `stall` is high only when an instruction is valid and some needed wait is above zero. `issue` is high only when an instruction is valid and not stalled. Both are low when no instruction is valid.
- R12: Only the fields a class uses are examined, and the integer and FP files are separate. A branch ignores its second source field. Class code 0 (no-op) and the undefined codes 6 and 7 never stall. An integer read of register n does not wait on a pending FP register n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Decode stage holds an instruction |
| instClass | input | 3 | Class code: 0 no-op, 1 integer op, 2 branch, 3 FP ALU, 4 load double, 5 store double |
| instDest | input | 5 | Destination register index |
| instSrcA | input | 5 | First source register index |
| instSrcB | input | 5 | Second source register index |
| stall | output | 1 | Hold the instruction in decode this cycle |
| issue | output | 1 | The instruction leaves decode this cycle |

## Verification
The hardest case to reach is a countdown that keeps running while the decode slot is busy with something else. Examples are an unrelated integer instruction issuing between an FP producer and its consumer, and an instruction that stalls on its own destination register. The stimulus reaches these cases with back-to-back dependent sequences and no idle gap between them, separated by idle stretches so that no countdown carries over from one case to the next. Each expected stall count comes from the pair latency minus the number of cycles already elapsed.

// File: rtl/issue_interlock_pkg.sv
package issue_interlock_pkg;

  localparam int REG_IDX_W = 5;
  localparam int CNT_W     = 2;

  typedef enum logic [2:0] {
    CLS_NOP   = 3'd0,
    CLS_INT   = 3'd1,
    CLS_BR    = 3'd2,
    CLS_FP    = 3'd3,
    CLS_LOAD  = 3'd4,
    CLS_STORE = 3'd5
  } inst_class_e;

  // Control-to-datapath strobes: arm one register's countdown.
  typedef struct packed {
    logic                 armEn;
    logic                 armFp;
    logic [REG_IDX_W-1:0] armIdx;
    logic [CNT_W-1:0]     armVal;
    logic                 armFromLoad;
  } arm_strobe_t;

endpackage

// File: rtl/issue_interlock_regs.sv
module issue_interlock_regs
  import issue_interlock_pkg::*;
#(
  parameter int NUM_INT_REGS = 32,
  parameter int NUM_FP_REGS  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  arm_strobe_t          strobe,
  input  logic [REG_IDX_W-1:0] rdIdxA,
  input  logic [REG_IDX_W-1:0] rdIdxB,
  output logic [CNT_W-1:0]     intCntA,
  output logic [CNT_W-1:0]     intCntB,
  output logic [CNT_W-1:0]     fpCntA,
  output logic [CNT_W-1:0]     fpCntB,
  output logic                 fpLoadA,
  output logic                 fpLoadB
);

  logic [CNT_W-1:0] intCnt [NUM_INT_REGS];
  logic [CNT_W-1:0] fpCnt  [NUM_FP_REGS];
  logic             fpLoad [NUM_FP_REGS];

  for (genvar r = 0; r < NUM_INT_REGS; r++) begin : g_intReg
    logic hit;
    assign hit = strobe.armEn && !strobe.armFp && (strobe.armIdx == REG_IDX_W'(r));
    always_ff @(posedge clk) begin
      if (rst) begin
        intCnt[r] <= '0;
      end else if (hit) begin
        intCnt[r] <= strobe.armVal;
      end else if (intCnt[r] != '0) begin
        intCnt[r] <= intCnt[r] - 1'b1;
      end
    end
  end

  for (genvar r = 0; r < NUM_FP_REGS; r++) begin : g_fpReg
    logic hit;
    assign hit = strobe.armEn && strobe.armFp && (strobe.armIdx == REG_IDX_W'(r));
    always_ff @(posedge clk) begin
      if (rst) begin
        fpCnt[r]  <= '0;
        fpLoad[r] <= 1'b0;
      end else if (hit) begin
        fpCnt[r]  <= strobe.armVal;
        fpLoad[r] <= strobe.armFromLoad;
      end else if (fpCnt[r] != '0) begin
        fpCnt[r]  <= fpCnt[r] - 1'b1;
      end
    end
  end

  always_comb begin
    intCntA = intCnt[rdIdxA];
    intCntB = intCnt[rdIdxB];
    fpCntA  = fpCnt[rdIdxA];
    fpCntB  = fpCnt[rdIdxB];
    fpLoadA = fpLoad[rdIdxA];
    fpLoadB = fpLoad[rdIdxB];
  end

endmodule

// File: rtl/issue_interlock_ctrl.sv
module issue_interlock_ctrl
  import issue_interlock_pkg::*;
#(
  parameter int LAT_FP_FP   = 3,
  parameter int LAT_FP_ST   = 2,
  parameter int LAT_LD_FP   = 1,
  parameter int LAT_LD_ST   = 0,
  parameter int LAT_INT_INT = 0,
  parameter int LAT_INT_BR  = 1
) (
  input  logic                 instValid,
  input  logic [2:0]           instClass,
  input  logic [REG_IDX_W-1:0] instDest,
  input  logic [REG_IDX_W-1:0] instSrcA,
  input  logic [REG_IDX_W-1:0] instSrcB,
  input  logic [CNT_W-1:0]     intCntA,
  input  logic [CNT_W-1:0]     intCntB,
  input  logic [CNT_W-1:0]     fpCntA,
  input  logic [CNT_W-1:0]     fpCntB,
  input  logic                 fpLoadA,
  input  logic                 fpLoadB,
  output logic                 stall,
  output logic                 issue,
  output arm_strobe_t          strobe
);

  // Worst-case wait each producer class can impose sets its arm value.
  localparam int WORST_FP  = (LAT_FP_FP > LAT_FP_ST) ? LAT_FP_FP : LAT_FP_ST;
  localparam int WORST_LD  = (LAT_LD_FP > LAT_LD_ST) ? LAT_LD_FP : LAT_LD_ST;
  localparam int WORST_INT = (LAT_INT_INT > LAT_INT_BR) ? LAT_INT_INT : LAT_INT_BR;

  function automatic logic [CNT_W-1:0] owed(input logic [CNT_W-1:0] cnt,
                                            input int lat, input int worst);
    int left;
    left = int'(cnt) + lat - worst;
    if (cnt != '0 && left > 0) return CNT_W'(left);
    return '0;
  endfunction

  inst_class_e cls;
  logic useIntA, useIntB, useFpA, useFpB;
  logic isBranch, isStore, writesInt, writesFp, fromLoad;
  logic [CNT_W-1:0] waitIntA, waitIntB, waitFpA, waitFpB;
  int latIntCons, latFpA, latFpB, worstFpA, worstFpB;

  assign cls = inst_class_e'(instClass);

  always_comb begin
    useIntA   = 1'b0;
    useIntB   = 1'b0;
    useFpA    = 1'b0;
    useFpB    = 1'b0;
    isBranch  = 1'b0;
    isStore   = 1'b0;
    writesInt = 1'b0;
    writesFp  = 1'b0;
    fromLoad  = 1'b0;
    unique case (cls)
      CLS_INT:   begin useIntA = 1'b1; useIntB = 1'b1; writesInt = 1'b1; end
      CLS_BR:    begin useIntA = 1'b1; isBranch = 1'b1; end
      CLS_FP:    begin useFpA = 1'b1; useFpB = 1'b1; writesFp = 1'b1; end
      CLS_LOAD:  begin useIntA = 1'b1; writesFp = 1'b1; fromLoad = 1'b1; end
      CLS_STORE: begin useIntA = 1'b1; useFpB = 1'b1; isStore = 1'b1; end
      default:   ;
    endcase
  end

  always_comb begin
    latIntCons = isBranch ? LAT_INT_BR : LAT_INT_INT;
    latFpA     = fpLoadA ? (isStore ? LAT_LD_ST : LAT_LD_FP)
                         : (isStore ? LAT_FP_ST : LAT_FP_FP);
    latFpB     = fpLoadB ? (isStore ? LAT_LD_ST : LAT_LD_FP)
                         : (isStore ? LAT_FP_ST : LAT_FP_FP);
    worstFpA   = fpLoadA ? WORST_LD : WORST_FP;
    worstFpB   = fpLoadB ? WORST_LD : WORST_FP;

    waitIntA = (useIntA && instSrcA != '0) ? owed(intCntA, latIntCons, WORST_INT) : '0;
    waitIntB = (useIntB && instSrcB != '0) ? owed(intCntB, latIntCons, WORST_INT) : '0;
    waitFpA  = useFpA ? owed(fpCntA, latFpA, worstFpA) : '0;
    waitFpB  = useFpB ? owed(fpCntB, latFpB, worstFpB) : '0;
  end

  assign stall = instValid && ((waitIntA | waitIntB | waitFpA | waitFpB) != '0);
  assign issue = instValid && !stall;

  always_comb begin
    strobe.armEn       = issue && (writesFp || (writesInt && instDest != '0));
    strobe.armFp       = writesFp;
    strobe.armIdx      = instDest;
    strobe.armFromLoad = fromLoad;
    if (writesFp) strobe.armVal = fromLoad ? CNT_W'(WORST_LD) : CNT_W'(WORST_FP);
    else          strobe.armVal = CNT_W'(WORST_INT);
  end

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import issue_interlock_pkg::*;
#(
  parameter int NUM_INT_REGS = 32,
  parameter int NUM_FP_REGS  = 32,
  parameter int LAT_FP_FP    = 3,
  parameter int LAT_FP_ST    = 2,
  parameter int LAT_LD_FP    = 1,
  parameter int LAT_LD_ST    = 0,
  parameter int LAT_INT_INT  = 0,
  parameter int LAT_INT_BR   = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       instValid,
  input  logic [2:0] instClass,
  input  logic [4:0] instDest,
  input  logic [4:0] instSrcA,
  input  logic [4:0] instSrcB,
  output logic       stall,
  output logic       issue
);

  arm_strobe_t      armStrobe;
  logic [CNT_W-1:0] intCntA, intCntB, fpCntA, fpCntB;
  logic             fpLoadA, fpLoadB;

  issue_interlock_regs #(
    .NUM_INT_REGS(NUM_INT_REGS),
    .NUM_FP_REGS (NUM_FP_REGS)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .strobe (armStrobe),
    .rdIdxA (instSrcA),
    .rdIdxB (instSrcB),
    .intCntA(intCntA),
    .intCntB(intCntB),
    .fpCntA (fpCntA),
    .fpCntB (fpCntB),
    .fpLoadA(fpLoadA),
    .fpLoadB(fpLoadB)
  );

  issue_interlock_ctrl #(
    .LAT_FP_FP  (LAT_FP_FP),
    .LAT_FP_ST  (LAT_FP_ST),
    .LAT_LD_FP  (LAT_LD_FP),
    .LAT_LD_ST  (LAT_LD_ST),
    .LAT_INT_INT(LAT_INT_INT),
    .LAT_INT_BR (LAT_INT_BR)
  ) u_ctrl (
    .instValid(instValid),
    .instClass(instClass),
    .instDest (instDest),
    .instSrcA (instSrcA),
    .instSrcB (instSrcB),
    .intCntA  (intCntA),
    .intCntB  (intCntB),
    .fpCntA   (fpCntA),
    .fpCntB   (fpCntB),
    .fpLoadA  (fpLoadA),
    .fpLoadB  (fpLoadB),
    .stall    (stall),
    .issue    (issue),
    .strobe   (armStrobe)
  );

endmodule

// File: rtl/issue_interlock_chk.sv
module issue_interlock_chk
  import issue_interlock_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       instValid,
  input logic [2:0] instClass,
  input logic [4:0] instDest,
  input logic [4:0] instSrcA,
  input logic [4:0] instSrcB,
  input logic       stall,
  input logic       issue
);

  // R11
  stall_issue_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(stall && issue));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> (!stall && !issue));

  // R1
  first_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !stall);

  // R2
  fp_fp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (instValid && instClass == CLS_FP && instSrcA == $past(instDest)
     && $past(issue && instClass == CLS_FP && !rst)) |-> stall);

  // R7
  branch_after_int_chk: assert property (@(posedge clk) disable iff (rst)
    (instValid && instClass == CLS_BR && instSrcA != 5'd0 && instSrcA == $past(instDest)
     && $past(issue && instClass == CLS_INT && !rst)) |-> stall);

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (instValid && instClass == CLS_BR && instSrcA == 5'd0) |-> !stall);

endmodule

bind issue_interlock issue_interlock_chk u_chk (.*);

// File: tb/issue_interlock_tb.sv
`timescale 1ns/1ps
module issue_interlock_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       instValid;
  logic [2:0] instClass;
  logic [4:0] instDest, instSrcA, instSrcB;
  logic       stall, issue;

  int checks = 0;
  int errors = 0;
  int expStallQ[$];
  string expReqQ[$];

  localparam logic [2:0] C_NOP = 3'd0, C_INT = 3'd1, C_BR = 3'd2,
                         C_FP = 3'd3, C_LD = 3'd4, C_ST = 3'd5;

  always #2 clk = ~clk;

  issue_interlock u_dut (
    .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
    .instDest(instDest), .instSrcA(instSrcA), .instSrcB(instSrcB),
    .stall(stall), .issue(issue)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: push expected stall count, present the instruction until it issues.
  task automatic sendInst(input logic [2:0] cls, input logic [4:0] d, input logic [4:0] a,
                          input logic [4:0] b, input int expStalls, input string req);
    expStallQ.push_back(expStalls);
    expReqQ.push_back(req);
    instClass = cls; instDest = d; instSrcA = a; instSrcB = b; instValid = 1'b1;
    do @(negedge clk); while (!issue);
    @(posedge clk); #1;
    instValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!stall && !issue, "R11", "idle outputs", {stall, issue}, 0);
    end
    @(posedge clk); #1;
  endtask

  // Monitor: count stall cycles per instruction, compare on issue.
  initial begin
    int stallCnt = 0;
    forever begin
      @(negedge clk);
      if (!rst && instValid) begin
        if (stall && issue) check(1'b0, "R11", "stall and issue together", 1, 0);
        if (stall) stallCnt++;
        else if (issue) begin
          if (expStallQ.size() == 0) check(1'b0, "R11", "unexpected issue", 1, 0);
          else begin
            int e;
            string r;
            e = expStallQ.pop_front();
            r = expReqQ.pop_front();
            check(stallCnt == e, r, "stall cycles", stallCnt, e);
          end
          stallCnt = 0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; instValid = 1'b0; instClass = '0; instDest = '0; instSrcA = '0; instSrcB = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!stall && !issue, "R1", "outputs in reset", {stall, issue}, 0);
    @(posedge clk); #1;
    rst = 1'b0;

    // R1: first instruction after reset
    sendInst(C_INT, 5'd1, 5'd2, 5'd3, 0, "R1");
    // R6: integer chain and load/store base
    sendInst(C_INT, 5'd2, 5'd1, 5'd1, 0, "R6");
    sendInst(C_LD,  5'd2, 5'd2, 5'd0, 0, "R6");
    // R5: store data straight from load
    sendInst(C_ST,  5'd0, 5'd2, 5'd2, 0, "R5");
    idle(4);
    // R2: FP ALU to FP ALU
    sendInst(C_FP, 5'd1, 5'd2, 5'd3, 0, "R2");
    sendInst(C_FP, 5'd4, 5'd3, 5'd1, 3, "R2");
    idle(4);
    // R3: FP ALU to store data
    sendInst(C_FP, 5'd5, 5'd6, 5'd7, 0, "R3");
    sendInst(C_ST, 5'd0, 5'd0, 5'd5, 2, "R3");
    idle(4);
    // R4: load to FP ALU
    sendInst(C_LD, 5'd8, 5'd1, 5'd0, 0, "R4");
    sendInst(C_FP, 5'd9, 5'd8, 5'd8, 1, "R4");
    idle(4);
    // R7: integer to branch, then an ordinary successor
    sendInst(C_INT, 5'd6, 5'd1, 5'd2, 0, "R7");
    sendInst(C_BR,  5'd0, 5'd6, 5'd0, 1, "R7");
    sendInst(C_INT, 5'd7, 5'd6, 5'd6, 0, "R7");
    idle(4);
    // R8: register 0 never waits
    sendInst(C_INT, 5'd0, 5'd1, 5'd1, 0, "R8");
    sendInst(C_BR,  5'd0, 5'd0, 5'd0, 0, "R8");
    sendInst(C_INT, 5'd3, 5'd0, 5'd0, 0, "R8");
    idle(4);
    // R9: elapsed cycles count toward the wait
    sendInst(C_FP,  5'd10, 5'd2, 5'd3, 0, "R9");
    sendInst(C_INT, 5'd8,  5'd1, 5'd2, 0, "R9");
    sendInst(C_FP,  5'd11, 5'd10, 5'd3, 2, "R9");
    idle(4);
    sendInst(C_FP, 5'd13, 5'd2, 5'd3, 0, "R9");
    sendInst(C_LD, 5'd15, 5'd1, 5'd0, 0, "R9");
    sendInst(C_ST, 5'd0,  5'd1, 5'd13, 1, "R9");
    idle(4);
    // R9: countdown keeps running through another instruction's stall
    sendInst(C_FP, 5'd21, 5'd2, 5'd3, 0, "R9");
    sendInst(C_FP, 5'd22, 5'd21, 5'd3, 3, "R9");
    sendInst(C_ST, 5'd0,  5'd1, 5'd21, 0, "R9");
    idle(4);
    // R10: self-dependent held instruction
    sendInst(C_FP, 5'd16, 5'd17, 5'd18, 0, "R10");
    sendInst(C_FP, 5'd16, 5'd16, 5'd18, 3, "R10");
    idle(4);
    // R12: unused fields and separate files
    sendInst(C_FP,  5'd20, 5'd2,  5'd3,  0, "R12");
    sendInst(C_INT, 5'd21, 5'd20, 5'd20, 0, "R12");
    sendInst(C_BR,  5'd0,  5'd3,  5'd20, 0, "R12");
    sendInst(C_NOP, 5'd0,  5'd20, 5'd20, 0, "R12");
    sendInst(3'd7,  5'd20, 5'd20, 5'd20, 0, "R12");
    idle(2);

    check(expStallQ.size() == 0, "R11", "pending expectations", expStallQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule